// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory buffers that software describes through a ring of 16-byte descriptors. For each slot it reads the descriptor's status word through a simple request/acknowledge memory port. If software has handed that descriptor over, the engine reads the buffer size, the end-of-ring marker and the buffer address. It then packs the incoming frame bytes into 32-bit words and stores them in the buffer. Last, it writes a status word back that carries the stored length, the first and last flags and an error flag, with the ownership bit cleared.

Software arms descriptors by setting the ownership bit and then holds the `start` input high. When the engine reaches a descriptor it does not own, it reports buffer-unavailable and suspends on that same descriptor until a `poll` strobe arrives. Dropping `start` lets the frame in progress finish, then the engine halts and reports stopped. A later start begins again from `ring_base`. Wrap-around is decided only by the end-of-ring bit inside each descriptor, so the ring can have any number of slots.

Top module: `rx_desc_dma`

## Requirements
- R1: While reset is held and after it is released with `start` low, `mem_req`, `rx_ready`, `rx_done`, `buf_unavail` and `stopped` are all low.
- R2: When `start` rises, the engine reads the status word at `ring_base`. If bit 31 (owned by engine) is clear, it pulses `buf_unavail` for one cycle and makes no further memory request until `poll` or a stop.
- R3: A `poll` strobe while suspended re-reads the same descriptor. The descriptor pointer is kept across a suspend.
- R4: For an owned descriptor the engine reads word offset 4 and word offset 8. Offset 4 carries the buffer size in bits 12:0 and the end-of-ring flag in bit 15. Offset 8 carries the buffer address. Offset 12 is never accessed (ring base 16-byte aligned).
- R5: Frame bytes are stored little-endian: byte n goes to lane n mod 4 of the 32-bit word at buffer address plus 4*(n div 4). The last partial word has zeros in its unused upper lanes. No word past the stored bytes is written.
- R6: While the engine waits for a frame, bytes offered without the start-of-frame flag are accepted and discarded.
- R7: The write-back status word has bit 31 = 0, bits 29:16 = stored length, bit 15 = error, bit 9 = first = 1, bit 8 = last = 1, and all other bits 0.
- R8: Bytes beyond the buffer size are accepted and dropped. The stored length then equals the buffer size and the error bit is set. A frame that exactly fills the buffer has error clear.
- R9: `rx_done` pulses for exactly one cycle after each status write-back completes. It never coincides with `buf_unavail`.
- R10: After a write-back the pointer advances by 16 bytes. If the descriptor had end-of-ring set, it returns to `ring_base` instead.
- R11: With `start` low, the engine finishes the current frame, pulses `stopped` in the same cycle as `rx_done`, and makes no more requests. It also stops, with a pulse, from the suspended state. The next start begins at `ring_base`.
- R12: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run enable level |
| poll | input | 1 | Poll-demand strobe, resumes a suspended engine |
| ring_base | input | 32 | Byte address of the first descriptor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_done | output | 1 | Pulse: status written back |
| buf_unavail | output | 1 | Pulse: descriptor not owned, suspended |
| stopped | output | 1 | Pulse: engine halted |

## Verification
The write-back that closes the last frame after `start` has dropped completes a descriptor and halts the engine in the same cycle. So `rx_done` and `stopped` are raised together. The bench provokes this by lowering `start` while the engine waits for frame bytes. It then counts both pulses, checks the written-back descriptor, and confirms that no memory request follows. A second overlap, a poll strobe that meets a suspended engine with `start` still high, is judged by which descriptor receives the next frame. A fixed-seed random sequence of frame lengths, junk bytes, stream gaps and memory latencies drives the ring through several wraps and truncations.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_STEP  = 16;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 15;
    localparam int STAT_LEN_W = 14;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_STAT,
        ST_FETCH_SIZE,
        ST_FETCH_BUF,
        ST_SUSPEND,
        ST_RECV,
        ST_FLUSH,
        ST_WR_WORD,
        ST_WRITEBACK
    } rx_state_e;

    function automatic logic [WORD_W-1:0] wb_status(input logic [STAT_LEN_W-1:0] len,
                                                    input logic err);
        logic [WORD_W-1:0] s;
        s        = '0;
        s[29:16] = len;
        s[15]    = err;
        s[9]     = 1'b1;
        s[8]     = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/rxdma_pack.sv
module rxdma_pack #(
    parameter int SIZE_W = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                take,
    input  logic [7:0]          byte_in,
    input  logic [SIZE_W-1:0]   buf_size,
    input  logic                word_sent,
    output logic [31:0]         word_o,
    output logic [SIZE_W:0]     word_off_o,
    output logic                word_full_o,
    output logic                has_data_o,
    output logic [SIZE_W:0]     stored_o,
    output logic                trunc_o
);
    localparam int CNT_W = SIZE_W + 1;

    typedef struct packed {
        logic [31:0]      word;
        logic [2:0]       lanes;
        logic [CNT_W-1:0] off;
        logic [CNT_W-1:0] stored;
        logic             trunc;
    } pack_s;

    pack_s q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (word_sent) begin
                d.word  = '0;
                d.lanes = '0;
                d.off   = q.off + CNT_W'(4);
            end
            if (take) begin
                if (q.stored < {1'b0, buf_size}) begin
                    d.word[{q.lanes[1:0], 3'b000} +: 8] = byte_in;
                    d.lanes  = q.lanes + 3'd1;
                    d.stored = q.stored + CNT_W'(1);
                end else begin
                    d.trunc = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o      = q.word;
    assign word_off_o  = q.off;
    assign word_full_o = (q.lanes == 3'd4);
    assign has_data_o  = (q.lanes != 3'd0);
    assign stored_o    = q.stored;
    assign trunc_o     = q.trunc;

    // R8: the stored count never passes the buffer size of the current descriptor
    a_r8_within_size: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (stored_o <= {1'b0, $past(buf_size)}));

    // R5: a full word is never extended before it is sent
    a_r5_no_fifth_lane: assert property (@(posedge clk) disable iff (!rst_n)
        word_full_o && !word_sent && !clr |=> word_full_o);

endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              poll,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              rx_ready,
    output logic              pk_clr,
    output logic              pk_take,
    output logic              pk_sent,
    output logic [SIZE_W-1:0] pk_size,
    input  logic [31:0]       pk_word,
    input  logic [SIZE_W:0]   pk_off,
    input  logic              pk_full,
    input  logic              pk_has,
    input  logic [SIZE_W:0]   pk_stored,
    input  logic              pk_trunc,
    output logic              rx_done,
    output logic              buf_unavail,
    output logic              stopped
);
    typedef struct packed {
        rx_state_e         st;
        logic [ADDR_W-1:0] cur;
        logic [SIZE_W-1:0] bsize;
        logic              eor;
        logic [ADDR_W-1:0] baddr;
        logic              in_frame;
        logic              eof_seen;
        logic              done;
        logic              unav;
        logic              stop;
    } ctrl_s;

    ctrl_s q, d;

    always_comb begin
        mem_req = (q.st == ST_FETCH_STAT) || (q.st == ST_FETCH_SIZE) ||
                  (q.st == ST_FETCH_BUF)  || (q.st == ST_WR_WORD)    ||
                  (q.st == ST_WRITEBACK);
        mem_we  = (q.st == ST_WR_WORD) || (q.st == ST_WRITEBACK);
        unique case (q.st)
            ST_FETCH_SIZE: mem_addr = q.cur + ADDR_W'(4);
            ST_FETCH_BUF:  mem_addr = q.cur + ADDR_W'(8);
            ST_WR_WORD:    mem_addr = q.baddr + ADDR_W'(pk_off);
            default:       mem_addr = q.cur;
        endcase
        if (q.st == ST_WR_WORD)        mem_wdata = pk_word;
        else if (q.st == ST_WRITEBACK) mem_wdata = wb_status(STAT_LEN_W'(pk_stored), pk_trunc);
        else                           mem_wdata = '0;
    end

    assign rx_ready = (q.st == ST_RECV) && !pk_full;
    assign pk_take  = rx_valid && rx_ready && (q.in_frame || rx_sof);
    assign pk_clr   = (q.st == ST_FETCH_SIZE) && mem_ack;
    assign pk_sent  = (q.st == ST_WR_WORD) && mem_ack;
    assign pk_size  = q.bsize;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.unav = 1'b0;
        d.stop = 1'b0;
        unique case (q.st)
            ST_IDLE: if (start) begin
                d.cur = ring_base;
                d.st  = ST_FETCH_STAT;
            end
            ST_FETCH_STAT: if (mem_ack) begin
                if (mem_rdata[OWN_BIT]) begin
                    d.st = ST_FETCH_SIZE;
                end else begin
                    d.unav = 1'b1;
                    d.st   = ST_SUSPEND;
                end
            end
            ST_SUSPEND: begin
                if (!start) begin
                    d.stop = 1'b1;
                    d.st   = ST_IDLE;
                end else if (poll) begin
                    d.st = ST_FETCH_STAT;
                end
            end
            ST_FETCH_SIZE: if (mem_ack) begin
                d.bsize = mem_rdata[SIZE_W-1:0];
                d.eor   = mem_rdata[EOR_BIT];
                d.st    = ST_FETCH_BUF;
            end
            ST_FETCH_BUF: if (mem_ack) begin
                d.baddr    = mem_rdata[ADDR_W-1:0];
                d.in_frame = 1'b0;
                d.eof_seen = 1'b0;
                d.st       = ST_RECV;
            end
            ST_RECV: begin
                if (pk_full) begin
                    d.st = ST_WR_WORD;
                end else if (pk_take) begin
                    d.in_frame = 1'b1;
                    if (rx_eof) begin
                        d.in_frame = 1'b0;
                        d.eof_seen = 1'b1;
                        d.st       = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: d.st = pk_has ? ST_WR_WORD : ST_WRITEBACK;
            ST_WR_WORD: if (mem_ack) begin
                d.st = q.eof_seen ? ST_WRITEBACK : ST_RECV;
            end
            ST_WRITEBACK: if (mem_ack) begin
                d.done = 1'b1;
                d.cur  = q.eor ? ring_base : q.cur + ADDR_W'(DESC_STEP);
                if (start) begin
                    d.st = ST_FETCH_STAT;
                end else begin
                    d.stop = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rx_done     = q.done;
    assign buf_unavail = q.unav;
    assign stopped     = q.stop;

    // R12: an open request holds its command until acknowledged
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R4: descriptor reads never touch the unused fourth word
    a_r4_no_word3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && (ring_base[3:0] == 4'h0) |-> mem_addr[3:2] != 2'b11);

    // R9: completion and buffer-unavailable are never raised together
    a_r9_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_done, buf_unavail}));

    // R9: completion lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R2: a suspended engine is quiet on the memory port
    a_r2_suspend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        buf_unavail |-> !mem_req);

    // R11: a stopped engine makes no request in the following cycle
    a_r11_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stopped && !start |=> !mem_req);

    // R6: the stream is only taken while the memory port is idle
    a_r6_ready_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !mem_req);

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              poll,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    output logic              rx_ready,
    output logic              rx_done,
    output logic              buf_unavail,
    output logic              stopped
);
    logic              pk_clr, pk_take, pk_sent, pk_full, pk_has, pk_trunc;
    logic [SIZE_W-1:0] pk_size;
    logic [31:0]       pk_word;
    logic [SIZE_W:0]   pk_off, pk_stored;

    rxdma_ctrl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .poll(poll), .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_ready(rx_ready),
        .pk_clr(pk_clr), .pk_take(pk_take), .pk_sent(pk_sent), .pk_size(pk_size),
        .pk_word(pk_word), .pk_off(pk_off), .pk_full(pk_full), .pk_has(pk_has),
        .pk_stored(pk_stored), .pk_trunc(pk_trunc),
        .rx_done(rx_done), .buf_unavail(buf_unavail), .stopped(stopped)
    );

    rxdma_pack #(.SIZE_W(SIZE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .take(pk_take), .byte_in(rx_data),
        .buf_size(pk_size), .word_sent(pk_sent), .word_o(pk_word), .word_off_o(pk_off),
        .word_full_o(pk_full), .has_data_o(pk_has), .stored_o(pk_stored), .trunc_o(pk_trunc)
    );

endmodule

// File: tb/rx_desc_dma_bench.sv
`timescale 1ns/1ps
module rx_desc_dma_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, poll = 1'b0;
    logic [31:0] ring_base = 32'h40;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_done, buf_unavail, stopped;

    int checks = 0, errors = 0;
    int done_cnt = 0, unav_cnt = 0, stop_cnt = 0, acc_cnt = 0;
    logic [31:0] mem [0:511];
    logic [7:0]  fb [0:63];
    int          nxt;

    always #2.5 clk = ~clk;

    rx_desc_dma u_rx_desc_dma (
        .clk(clk), .rst_n(rst_n), .start(start), .poll(poll), .ring_base(ring_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .rx_ready(rx_ready), .rx_done(rx_done), .buf_unavail(buf_unavail), .stopped(stopped)
    );

    // memory model with random acknowledge latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[10:2]];
            if (mem_we) mem[mem_addr[10:2]] = mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rx_done)     done_cnt++;
        if (buf_unavail) unav_cnt++;
        if (stopped)     stop_cnt++;
        if (mem_ack)     acc_cnt++;
    end

    function automatic int bsize(input int i);
        case (i)
            0: return 48;
            1: return 10;
            2: return 48;
            default: return 20;
        endcase
    endfunction

    function automatic logic [31:0] exp_status(input int len, input logic err);
        logic [31:0] s;
        s = '0;
        s[29:16] = len[13:0];
        s[15] = err;
        s[9] = 1'b1;
        s[8] = 1'b1;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic arm(input int i);
        int d = (32'h40 + 16 * i) / 4;
        int b = (32'h100 + 64 * i) / 4;
        mem[d]     = 32'h8000_0000;
        mem[d + 1] = bsize(i) | ((i == 3) ? 32'h8000 : 32'h0);
        mem[d + 2] = 32'h100 + 64 * i;
        mem[d + 3] = 32'hFFFF_FFFF;
        for (int w = 0; w < 16; w++) mem[b + w] = 32'hDEAD_BEEF;
    endtask

    task automatic push(input logic [7:0] b, input logic s, input logic e);
        rx_valid = 1'b1; rx_data = b; rx_sof = s; rx_eof = e;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input int junk);
        for (int j = 0; j < junk; j++) push(8'($urandom), 1'b0, 1'b0);
        for (int k = 0; k < len; k++) begin
            fb[k] = 8'($urandom);
            push(fb[k], k == 0, k == len - 1);
        end
    endtask

    task automatic wait_done(input int prev);
        while (done_cnt == prev) @(negedge clk);
    endtask

    task automatic check_desc(input int i, input int len);
        int d = (32'h40 + 16 * i) / 4;
        int b = (32'h100 + 64 * i) / 4;
        int st = (len > bsize(i)) ? bsize(i) : len;
        logic [31:0] ew;
        logic bad = 1'b0;
        logic [31:0] first_act = '0, first_exp = '0;
        check((len > bsize(i)) ? "R8 truncated status" : "R7 status word",
              mem[d], exp_status(st, len > bsize(i)));
        for (int w = 0; w < 16; w++) begin
            if (w * 4 < st) begin
                for (int l = 0; l < 4; l++) ew[l*8 +: 8] = (w * 4 + l < st) ? fb[w * 4 + l] : 8'h00;
            end else begin
                ew = 32'hDEAD_BEEF;
            end
            if (mem[b + w] !== ew && !bad) begin
                bad = 1'b1; first_act = mem[b + w]; first_exp = ew;
            end
        end
        check("R5 buffer contents", first_act, first_exp);
        check("R4 fourth word untouched", mem[d + 3], 32'hFFFF_FFFF);
    endtask

    task automatic frame_step(input int len, input int junk);
        int prev = done_cnt;
        send_frame(len, junk);
        wait_done(prev);
        check("R9 one done pulse", 32'(done_cnt), 32'(prev + 1));
        check_desc(nxt, len);
        arm(nxt);
        nxt = (nxt + 1) % 4;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        int a;
        void'($urandom(32'h5EED_0123));
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {27'b0, mem_req, rx_ready, rx_done, buf_unavail, stopped}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle outputs", {27'b0, mem_req, rx_ready, rx_done, buf_unavail, stopped}, 32'h0);

        // descriptor 0 not owned: expect suspend
        arm(1); arm(2); arm(3);
        mem[16] = 32'h0; mem[17] = 48; mem[18] = 32'h100; mem[19] = 32'hFFFF_FFFF;
        for (int w = 0; w < 16; w++) mem[64 + w] = 32'hDEAD_BEEF;
        start = 1'b1;
        while (unav_cnt == 0) @(negedge clk);
        a = acc_cnt;
        repeat (20) @(negedge clk);
        check("R2 no access while suspended", 32'(acc_cnt), 32'(a));
        check("R2 one unavailable pulse", 32'(unav_cnt), 32'd1);
        mem[16] = 32'h8000_0000;
        poll = 1'b1; @(negedge clk); poll = 1'b0;
        nxt = 0;
        frame_step(13, 3);      // R3 same descriptor resumed, R6 junk dropped
        frame_step(15, 0);      // R8 truncation in 10-byte buffer
        frame_step(1, 0);       // single-byte frame
        frame_step(20, 0);      // R8 exact fill, end-of-ring descriptor
        frame_step(48, 2);      // R10 wrapped back to descriptor 0
        for (int r = 0; r < 12; r++) frame_step($urandom_range(1, 52), $urandom_range(0, 2));

        // stop at a frame boundary
        begin
            int prev_stop = stop_cnt;
            start = 1'b0;
            frame_step(7, 0);
            repeat (2) @(negedge clk);
            check("R11 stopped pulse", 32'(stop_cnt), 32'(prev_stop + 1));
            a = acc_cnt;
            repeat (30) @(negedge clk);
            check("R11 no access after stop", 32'(acc_cnt), 32'(a));
        end
        check("R11 stop left engine off descriptor 0", 32'(nxt != 0), 32'd1);
        nxt = 0;
        start = 1'b1;
        frame_step(9, 1);       // R11 restart begins at ring base

        // stop from suspended state
        begin
            int prev_unav = unav_cnt, prev_stop = stop_cnt;
            mem[(32'h40 + 16 * nxt) / 4] = 32'h0;
            while (unav_cnt == prev_unav) @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            check("R11 stop from suspend", 32'(stop_cnt), 32'(prev_stop + 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule